// File: doc/BRIEF.md
# Switchable-Polarity Reed-Muller Spectrum Network

This block turns the truth table of a three-input Boolean function into its Reed-Muller (AND/XOR) coefficients. Each variable can appear as a plain literal or as a complemented literal, and a polarity word chooses which form each variable takes. The truth table arrives as an 8-bit vector, where bit `i` holds the function value at the input point whose binary code is `i`. The coefficient vector leaves on an 8-bit output, where bit `j` is set when the product term built from the variables named by the set bits of `j` appears in the expansion.

The network is a cascade of three butterfly levels. Each level combines bit pairs at a fixed distance. Every level builds both its plain-literal result and its complemented-literal result side by side, and one polarity bit picks between the two. A single datapath therefore serves all eight polarities. The block is purely combinational, with no clock and no reset. A search engine can sweep the polarity input over its eight codes and compare the cost of each result.

Top module: `rm_polarity_xform`

## Requirements
- R1: A level whose polarity bit is 0 maps each pair (low position `a`, high position `b`) to `a` in the low position and `a XOR b` in the high position.
- R2: A level whose polarity bit is 1 maps each pair (`a`, `b`) to `b` in the low position and `a XOR b` in the high position. The high-position result is the same for both polarity choices.
- R3: The first level pairs bits at distance 4, the second at distance 2 and the third at distance 1. Polarity bit 2 drives the first level, bit 1 the second level and bit 0 the third level.
- R4: For every polarity code `p`, coefficient bit 0 equals the function vector bit at index `p`.
- R5: For every polarity code, coefficient bit 7 equals the XOR of all eight function vector bits.
- R6: All eight polarity codes 0 through 7 are accepted. For a function vector `f` and polarity `p`, coefficient bit `j` equals the XOR of `f[i XOR p]` over all indices `i` whose set bits are a subset of the set bits of `j`.
- R7: An all-zero function vector gives an all-zero coefficient vector for every polarity. An all-ones function vector gives 8'h01 for every polarity.
- R8: The output follows the inputs without any clock. A new input value shows up at the output within the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| func_vec | input | 8 | Truth table of the function; bit i is the value at input point i |
| polarity | input | 3 | Literal choice per variable; 1 selects the complemented form |
| coef | output | 8 | Reed-Muller coefficient vector for the chosen polarity |

## Verification
On every input change, the assertions check that each level's output can be undone back into that level's input for the selected polarity. They also check that the high positions of the two polarity variants agree, that coefficient 0 picks the function value at the polarity point, and that the top coefficient is the parity of the function. Only the bench's scenarios can show that the whole cascade matches the subset-XOR definition for every input and polarity. The same goes for the mapping of the polarity bits onto the levels, and for the settled results on constant and single-minterm functions.

// File: rtl/rmx_pkg.sv
package rmx_pkg;

  // Number of input variables handled by default.
  localparam int RMX_NVARS = 3;

  // Pair distance used at butterfly level lv (0 = first level).
  function automatic int level_span(input int width, input int lv);
    return width >> (lv + 1);
  endfunction

endpackage

// File: rtl/rm_level.sv
module rm_level #(
  parameter int W    = 8,
  parameter int SPAN = 4
) (
  input  logic [W-1:0] lvl_in,
  input  logic         neg_sel,
  output logic [W-1:0] lvl_out
);

  localparam int NGROUP = W / (2 * SPAN);

  // Both polarity variants, brought out for the checks below.
  logic [W-1:0] pos_vec;
  logic [W-1:0] neg_vec;
  logic [W-1:0] pair_xor;

  for (genvar g = 0; g < NGROUP; g++) begin : g_group
    for (genvar k = 0; k < SPAN; k++) begin : g_pair
      localparam int LO = g * 2 * SPAN + k;
      localparam int HI = LO + SPAN;
      assign pair_xor[LO] = 1'b0;
      assign pair_xor[HI] = lvl_in[LO] ^ lvl_in[HI];
      assign pos_vec[LO]  = lvl_in[LO];
      assign pos_vec[HI]  = pair_xor[HI];
      assign neg_vec[LO]  = lvl_in[HI];
      assign neg_vec[HI]  = pair_xor[HI];
    end
  end

  assign lvl_out = neg_sel ? neg_vec : pos_vec;

  // Recover the level input from its output, for either polarity.
  function automatic logic [W-1:0] undo_level(input logic [W-1:0] v, input logic neg);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if ((i & SPAN) == 0) begin
        if (neg) begin
          r[i + SPAN] = v[i];
          r[i]        = v[i] ^ v[i + SPAN];
        end else begin
          r[i]        = v[i];
          r[i + SPAN] = v[i] ^ v[i + SPAN];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] high_mask();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = ((i & SPAN) != 0);
    return m;
  endfunction

  always_comb begin
    if (!$isunknown({lvl_in, neg_sel})) begin
      // R1 R2
      level_undo_chk: assert (undo_level(lvl_out, neg_sel) == lvl_in)
        else $error("level output does not invert back to its input");
      // R2
      high_agree_chk: assert (((pos_vec ^ neg_vec) & high_mask()) == '0)
        else $error("polarity variants differ on high positions");
    end
  end

endmodule

// File: rtl/rm_polarity_xform.sv
module rm_polarity_xform #(
  parameter int NVARS = rmx_pkg::RMX_NVARS
) (
  input  logic [(1<<NVARS)-1:0] func_vec,
  input  logic [NVARS-1:0]      polarity,
  output logic [(1<<NVARS)-1:0] coef
);

  localparam int W = 1 << NVARS;

  logic [W-1:0]     stage_vec [NVARS+1];
  logic [NVARS-1:0] level_sel;

  assign stage_vec[0] = func_vec;

  for (genvar lv = 0; lv < NVARS; lv++) begin : g_level
    // First level takes the most significant polarity bit.
    assign level_sel[lv] = polarity[NVARS-1-lv];
    rm_level #(
      .W    (W),
      .SPAN (rmx_pkg::level_span(W, lv))
    ) u_level (
      .lvl_in  (stage_vec[lv]),
      .neg_sel (level_sel[lv]),
      .lvl_out (stage_vec[lv+1])
    );
  end

  assign coef = stage_vec[NVARS];

  always_comb begin
    if (!$isunknown({func_vec, polarity})) begin
      // R4
      dc_term_chk: assert (coef[0] == func_vec[polarity])
        else $error("constant coefficient not taken at polarity point");
      // R5
      parity_term_chk: assert (coef[W-1] == ^func_vec)
        else $error("top coefficient is not the function parity");
    end
  end

endmodule

// File: tb/rm_polarity_xform_bench.sv
module rm_polarity_xform_bench;

  logic       clk = 1'b0;
  logic [7:0] func_vec = 8'h00;
  logic [2:0] polarity = 3'd0;
  logic [7:0] coef;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  rm_polarity_xform u_rm_polarity_xform (
    .func_vec (func_vec),
    .polarity (polarity),
    .coef     (coef)
  );

  // {function, polarity, expected coefficients}, worked out by hand
  localparam logic [18:0] VEC [10] = '{
    {8'h00, 3'd5, 8'h00},   // R7 zero function
    {8'hFF, 3'd3, 8'h01},   // R7 constant one
    {8'h80, 3'd0, 8'h80},   // R6 x2x1x0, plain literals
    {8'h01, 3'd0, 8'hFF},   // R1 minterm 0, all plain
    {8'h01, 3'd7, 8'h80},   // R2 minterm 0, all complemented
    {8'h80, 3'd7, 8'hFF},   // R2 x2x1x0, all complemented
    {8'h02, 3'd0, 8'hAA},   // R1 minterm 1
    {8'hAA, 3'd0, 8'h02},   // R3 f = x0, plain
    {8'hAA, 3'd1, 8'h03},   // R3 f = x0, bit0 drives last level
    {8'h96, 3'd7, 8'h17}    // R5 three-input parity, complemented
  };

  function automatic logic [7:0] model(input logic [7:0] f, input logic [2:0] p);
    logic [7:0] c;
    for (int j = 0; j < 8; j++) begin
      c[j] = 1'b0;
      for (int i = 0; i < 8; i++)
        if ((i & ~j & 7) == 0) c[j] ^= f[i ^ p];
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s f=%h p=%0d actual=%h expected=%h", tag, func_vec, polarity, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] f, input logic [2:0] p);
    @(posedge clk);
    func_vec = f;
    polarity = p;
    @(negedge clk);
  endtask

  initial begin
    // R7 state at start: zero input gives zero output
    @(negedge clk);
    check("R7", coef, 8'h00);

    for (int t = 0; t < 10; t++) begin
      apply(VEC[t][18:11], VEC[t][10:8]);
      check("R6", coef, VEC[t][7:0]);
    end

    // R6 exhaustive sweep against the subset-XOR definition
    for (int f = 0; f < 256; f++)
      for (int p = 0; p < 8; p++) begin
        apply(f[7:0], p[2:0]);
        check("R6", coef, model(f[7:0], p[2:0]));
        check("R4", {7'd0, coef[0]}, {7'd0, func_vec[p[2:0]]});
        check("R5", {7'd0, coef[7]}, {7'd0, ^func_vec});
      end

    // R3 single-variable functions show which polarity bit drives which level
    apply(8'hF0, 3'd4); check("R3", coef, 8'h11);
    apply(8'hF0, 3'd3); check("R3", coef, 8'h10);
    apply(8'hCC, 3'd2); check("R3", coef, 8'h05);
    apply(8'hCC, 3'd5); check("R3", coef, 8'h04);

    // R7 constants across all polarities
    for (int p = 0; p < 8; p++) begin
      apply(8'h00, p[2:0]); check("R7", coef, 8'h00);
      apply(8'hFF, p[2:0]); check("R7", coef, 8'h01);
    end

    // R8 output follows input without a clock edge
    @(negedge clk);
    func_vec = 8'h80; polarity = 3'd0;
    #1 check("R8", coef, 8'h80);
    polarity = 3'd7;
    #1 check("R8", coef, 8'hFF);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule